// File: doc/BRIEF.md
# Micro-Address Execution Histogram Monitor

The block sits beside a microsequenced processor and watches two things each cycle: the micro-address being executed and whether that cycle was stalled. While collection is running, every observed cycle adds one to a counter (a bucket) selected by that micro-address. There are two independent sets of buckets. Cycles that made progress count in the flow bank. Cycles lost to a memory read or write stall count in the stall bank. The monitor only receives signals from the processor and drives nothing back, so it never slows the processor or changes what it does.

A small command port controls collection. It accepts four commands: start, stop, wipe all buckets, and read one bucket. Each increment is a two-stage read-modify-write on the bucket memory. When the same bucket is hit on consecutive cycles, the value still being written is forwarded so that no count is lost. Buckets saturate rather than wrap. The default counter width of 36 bits covers more than two hours of cycles at 200 ns without reaching saturation. Set the address width to 14 to give one bucket for each location of a 16K-entry control store.

The control state machine has three states. ST_IDLE means stopped. ST_RUN means collecting. ST_WIPE means the clear walk is in progress. The transitions are:
- ST_IDLE to ST_RUN on a start command.
- ST_IDLE to ST_WIPE on a wipe command, once the increment pipeline is empty.
- ST_RUN to ST_IDLE on a stop command.
- ST_WIPE to ST_IDLE after the last address has been written.

Top module: `uaddr_profiler`

## Requirements
- R1: After reset, running, clear_busy, rd_valid and rd_err are all 0.
- R2: A start command (cmd_op 0) issued while stopped and not wiping sets running on the next cycle. A stop command (cmd_op 1) issued while running clears running on the next cycle.
- R3: While running, each cycle with probe_valid=1 and probe_stall=0 adds one to the flow-bank bucket (cmd_bank 0) at probe_uaddr. Probe activity while stopped changes no bucket.
- R4: While running, each cycle with probe_valid=1 and probe_stall=1 adds one to the stall-bank bucket (cmd_bank 1) at probe_uaddr and leaves the flow bank untouched.
- R5: Any number of consecutive cycles that hit the same bucket are all counted.
- R6: A bucket holding all ones stays at all ones when it is hit again.
- R7: A wipe command (cmd_op 2) issued while stopped holds clear_busy high for exactly 2^ADDR_W cycles and zeroes every bucket in both banks. A start command issued during the wipe is ignored.
- R8: A read command (cmd_op 3) issued while stopped, with cmd_addr and cmd_bank, pulses rd_valid on the next cycle with that bucket's count on rd_data.
- R9: A read command issued while running or wiping pulses rd_err on the next cycle instead of rd_valid, and collection continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the observed processor |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_valid | input | 1 | An observed microinstruction cycle is present |
| probe_stall | input | 1 | The observed cycle was stalled (selects the stall bank) |
| probe_uaddr | input | ADDR_W | Micro-address of the observed cycle |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 start, 1 stop, 2 wipe, 3 read |
| cmd_addr | input | ADDR_W | Bucket address for a read |
| cmd_bank | input | 1 | Bank for a read: 0 flow, 1 stall |
| running | output | 1 | Collection active |
| clear_busy | output | 1 | Wipe walk in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_err | output | 1 | Read refused pulse |
| rd_data | output | CNT_W | Bucket count returned by a read |

## Verification
The bench builds the monitor with ADDR_W=4 and CNT_W=8. With only 16 buckets, random micro-addresses often repeat on back-to-back cycles, which exercises the forwarding path many times. The full wipe walk takes only 16 cycles, so its exact length can be counted. An 8-bit bucket reaches saturation after a few hundred cycles on one address, which makes the no-wrap rule reachable within a short run.

// File: rtl/uprof_pkg.sv
package uprof_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_READ  = 2'd3
    } host_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WIPE = 2'd2
    } mon_state_e;

    localparam logic BANK_FLOW  = 1'b0;
    localparam logic BANK_STALL = 1'b1;

endpackage

// File: rtl/uprof_ctrl.sv
module uprof_ctrl
    import uprof_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  host_op_e          cmd_op,
    input  logic              pipe_busy,
    output logic              running,
    output logic              wiping,
    output logic              clr_we,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              rd_valid,
    output logic              rd_err
);
    localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

    mon_state_e        st, st_n;
    logic [ADDR_W-1:0] wipe_idx;
    logic              rd_req, rd_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next-state decode
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_valid && cmd_op == OP_START)
                    st_n = ST_RUN;
                else if (cmd_valid && cmd_op == OP_CLEAR && !pipe_busy)
                    st_n = ST_WIPE;
            end
            ST_RUN: begin
                if (cmd_valid && cmd_op == OP_STOP)
                    st_n = ST_IDLE;
            end
            ST_WIPE: begin
                if (wipe_idx == LAST_IDX)
                    st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        running  = (st == ST_RUN);
        wiping   = (st == ST_WIPE);
        clr_we   = (st == ST_WIPE);
        clr_addr = wipe_idx;
    end

    // wipe walk index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             wipe_idx <= '0;
        else if (st != ST_WIPE) wipe_idx <= '0;
        else                    wipe_idx <= wipe_idx + 1'b1;
    end

    assign rd_req = cmd_valid && (cmd_op == OP_READ);
    assign rd_ok  = (st == ST_IDLE) && !pipe_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
        end else begin
            rd_valid <= rd_req && rd_ok;
            rd_err   <= rd_req && !rd_ok;
        end
    end

endmodule

// File: rtl/uprof_store.sv
module uprof_store #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 36
) (
    input  logic              clk,
    input  logic              r_bank,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              we,
    input  logic              w_bank,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [CNT_W-1:0]  w_data,
    input  logic              clr_we,
    input  logic [ADDR_W-1:0] clr_addr,
    output logic [CNT_W-1:0]  rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic             r_bank_q;
    logic [CNT_W-1:0] q_flow, q_stall;

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            logic [CNT_W-1:0] cells [DEPTH];
            logic [CNT_W-1:0] rd_reg;

            always_ff @(posedge clk) begin
                if (clr_we)
                    cells[clr_addr] <= '0;
                else if (we && (w_bank == b[0]))
                    cells[w_addr] <= w_data;
                rd_reg <= cells[r_addr];
            end
        end
    endgenerate

    always_ff @(posedge clk) r_bank_q <= r_bank;

    assign q_flow  = g_bank[0].rd_reg;
    assign q_stall = g_bank[1].rd_reg;
    assign rd_q    = r_bank_q ? q_stall : q_flow;

endmodule

// File: rtl/uprof_rmw.sv
module uprof_rmw #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              acc_bank,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CNT_W-1:0]  rd_q,
    output logic              we,
    output logic              w_bank,
    output logic [ADDR_W-1:0] w_addr,
    output logic [CNT_W-1:0]  w_data,
    output logic              busy
);
    logic              s1_v, s1_bank;
    logic [ADDR_W-1:0] s1_addr;
    logic              fwd_hit;
    logic [CNT_W-1:0]  fwd_val, old_eff;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    assign old_eff = fwd_hit ? fwd_val : rd_q;
    assign w_data  = sat_inc(old_eff);
    assign we      = s1_v;
    assign w_bank  = s1_bank;
    assign w_addr  = s1_addr;
    assign busy    = s1_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_bank <= 1'b0;
            s1_addr <= '0;
            fwd_hit <= 1'b0;
            fwd_val <= '0;
        end else begin
            s1_v    <= acc;
            s1_bank <= acc_bank;
            s1_addr <= acc_addr;
            fwd_hit <= acc && s1_v && (acc_bank == s1_bank) && (acc_addr == s1_addr);
            fwd_val <= w_data;
        end
    end

endmodule

// File: rtl/uaddr_profiler.sv
module uaddr_profiler
    import uprof_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_valid,
    input  logic              probe_stall,
    input  logic [ADDR_W-1:0] probe_uaddr,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_bank,
    output logic              running,
    output logic              clear_busy,
    output logic              rd_valid,
    output logic              rd_err,
    output logic [CNT_W-1:0]  rd_data
);
    logic              pipe_busy, clr_we, acc;
    logic [ADDR_W-1:0] clr_addr, r_addr, w_addr;
    logic              r_bank, we, w_bank;
    logic [CNT_W-1:0]  w_data, rd_q;

    uprof_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (host_op_e'(cmd_op)),
        .pipe_busy (pipe_busy),
        .running   (running),
        .wiping    (clear_busy),
        .clr_we    (clr_we),
        .clr_addr  (clr_addr),
        .rd_valid  (rd_valid),
        .rd_err    (rd_err)
    );

    assign acc    = running && probe_valid;
    assign r_addr = running ? probe_uaddr : cmd_addr;
    assign r_bank = running ? probe_stall : cmd_bank;

    uprof_rmw #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .acc_bank (probe_stall),
        .acc_addr (probe_uaddr),
        .rd_q     (rd_q),
        .we       (we),
        .w_bank   (w_bank),
        .w_addr   (w_addr),
        .w_data   (w_data),
        .busy     (pipe_busy)
    );

    uprof_store #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .r_bank   (r_bank),
        .r_addr   (r_addr),
        .we       (we),
        .w_bank   (w_bank),
        .w_addr   (w_addr),
        .w_data   (w_data),
        .clr_we   (clr_we),
        .clr_addr (clr_addr),
        .rd_q     (rd_q)
    );

    assign rd_data = rd_q;

endmodule

// File: rtl/uaddr_profiler_chk.sv
module uaddr_profiler_chk
    import uprof_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       running,
    input logic       clear_busy,
    input logic       rd_valid,
    input logic       rd_err
);
    // R7
    wipe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && clear_busy));

    // R7
    wipe_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_busy |=> !running);

    // R8
    rd_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_err));

    // R9
    rd_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && running) |=> (rd_err && !rd_valid && running));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_START && !running && !clear_busy) |=> running);

    // R2
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STOP && running) |=> !running);

endmodule

bind uaddr_profiler uaddr_profiler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .running    (running),
    .clear_busy (clear_busy),
    .rd_valid   (rd_valid),
    .rd_err     (rd_err)
);

// File: tb/tb_uaddr_profiler.sv
`timescale 1ns/1ps
module tb_uaddr_profiler;
    localparam int AW    = 4;
    localparam int CW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SATV  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          probe_valid = 1'b0, probe_stall = 1'b0;
    logic [AW-1:0] probe_uaddr = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_bank = 1'b0;
    logic          running, clear_busy, rd_valid, rd_err;
    logic [CW-1:0] rd_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int exp_cnt [2][DEPTH];

    always #10 clk = ~clk;

    uaddr_profiler #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_stall(probe_stall),
        .probe_uaddr(probe_uaddr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .running(running),
        .clear_busy(clear_busy), .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bump(input int v);
        return (v >= SATV) ? SATV : v + 1;
    endfunction

    task automatic do_cmd(input logic [1:0] op, input int addr, input logic bank);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_bank = bank;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic bank, input int addr);
        do_cmd(2'd3, addr, bank);
        chk({req, " rd_valid"}, int'(rd_valid), 1);
        chk({req, " data"}, int'(rd_data), exp_cnt[bank][addr]);
    endtask

    task automatic stop_drain();
        probe_valid = 1'b0;
        do_cmd(2'd1, 0, 1'b0);
        chk("R2 stop", int'(running), 0);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic drive(input logic v, input logic s, input int a);
        probe_valid = v; probe_stall = s; probe_uaddr = AW'(a);
        if (v) exp_cnt[s][a] = bump(exp_cnt[s][a]);
        @(negedge clk);
    endtask

    task automatic wipe_and_verify(input string tag);
        int n;
        do_cmd(2'd2, 0, 1'b0);
        n = 0;
        while (clear_busy && n < 100) begin
            if (n == 3) begin cmd_valid = 1'b1; cmd_op = 2'd0; end
            else cmd_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk({"R7 wipe length ", tag}, n, DEPTH);
        chk({"R7 start ignored ", tag}, int'(running), 0);
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++) exp_cnt[b][a] = 0;
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++) read_chk({"R7 R8 zero ", tag}, b[0], a);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1
        chk("R1 running", int'(running), 0);
        chk("R1 clear_busy", int'(clear_busy), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_err", int'(rd_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        wipe_and_verify("first");

        // R5 back-to-back same bucket, both banks
        do_cmd(2'd0, 0, 1'b0);
        chk("R2 start", int'(running), 1);
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 3);
        for (int i = 0; i < 6; i++) drive(1'b1, i[0], 9);
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 9);
        stop_drain();
        read_chk("R5 flow run", 1'b0, 3);
        read_chk("R5 flow alt", 1'b0, 9);
        read_chk("R5 stall", 1'b1, 9);
        chk("R5 expected five", exp_cnt[0][3], 5);

        // R3 R4 random traffic
        do_cmd(2'd0, 0, 1'b0);
        for (int i = 0; i < 800; i++)
            drive(($urandom % 4) != 0, ($urandom % 3) == 0, int'($urandom % DEPTH));
        stop_drain();
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++)
                read_chk(b == 0 ? "R3 flow bank" : "R4 stall bank", b[0], a);

        // R3 probes while stopped are ignored
        for (int i = 0; i < 10; i++) begin
            probe_valid = 1'b1; probe_stall = i[0]; probe_uaddr = AW'(5);
            @(negedge clk);
        end
        probe_valid = 1'b0;
        @(negedge clk);
        read_chk("R3 idle ignored flow", 1'b0, 5);
        read_chk("R3 idle ignored stall", 1'b1, 5);

        // R9 read while running
        do_cmd(2'd0, 0, 1'b0);
        do_cmd(2'd3, 2, 1'b0);
        chk("R9 rd_err", int'(rd_err), 1);
        chk("R9 no rd_valid", int'(rd_valid), 0);
        chk("R9 still running", int'(running), 1);

        // R6 saturation
        for (int i = 0; i < 300; i++) drive(1'b1, 1'b0, 7);
        stop_drain();
        read_chk("R6 saturated", 1'b0, 7);
        chk("R6 model", exp_cnt[0][7], SATV);

        // R9 read during wipe, then final wipe
        do_cmd(2'd2, 0, 1'b0);
        do_cmd(2'd3, 1, 1'b0);
        chk("R9 rd_err wiping", int'(rd_err), 1);
        repeat (DEPTH + 2) @(negedge clk);
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++) exp_cnt[b][a] = 0;
        read_chk("R7 zero after saturation", 1'b0, 7);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule